// File: doc/BRIEF.md
# Circular-Buffer DMA Transfer Channel

This block is one DMA channel that streams 32-bit words from a ring buffer in memory to a single peripheral data register. The peripheral asks for data with a request strobe. Each accepted request starts a minor loop, which is a fixed burst of read-then-write beats. A fixed number of minor loops makes one major loop. When a major loop finishes, the channel raises a one-cycle interrupt. The loop counters then reload, and the channel waits for the next request, so streaming continues with no reprogramming.

The source address moves by a fixed step on every beat. Only the low `MOD_BITS` bits of the address may change. The upper bits stay at the value of the programmed base, so the reads wrap inside a power-of-two window aligned to that window's size. The destination address never changes. If a read or write ends with an error response, the channel stops and holds an error flag until it is disarmed.

The descriptor is taken from the `arm`, `src_base` and `dst_addr` inputs. While the channel is disarmed it idles and reloads both addresses from these inputs. Raising `arm` starts it. The default parameters give 16 beats per minor loop, 512 minor loops per major loop, a +4 step and a 128 KiB window.

Top module: `circ_dma_channel`

## Requirements
- R1: While reset is asserted, and after reset with `arm` low, `mem_rd_req`, `per_wr_req`, `irq` and `err` are all 0.
- R2: Each request accepted while the channel waits runs exactly `MINOR_BEATS` beats. Each beat is one memory read followed by one peripheral write, and the write carries the data returned by that read. The two request strobes are never high together.
- R3: Within a loop, each beat reads from the previous beat's address plus `SRC_STEP`. The first read after arming uses `src_base`. A read address stays stable until the read is acknowledged.
- R4: Source addresses wrap modulo 2^`MOD_BITS`. Bits `ADDR_W-1` down to `MOD_BITS` of every read address equal the same bits of `src_base`.
- R5: Every peripheral write goes to `dst_addr`. The destination offset is zero.
- R6: A request that arrives while a minor loop is running is ignored. It produces no extra beats.
- R7: `irq` is high for exactly one cycle, the cycle after the last write of every `MAJOR_COUNT`-th minor loop. The loop counts then restart, and the channel stays armed.
- R8: `buf_pos` shows the low `MOD_BITS` bits of the next source address. One major loop advances it by `MINOR_BEATS`*`MAJOR_COUNT`*`SRC_STEP`, modulo 2^`MOD_BITS`.
- R9: A read or write acknowledged with its error bit set halts the channel. `err` goes high and stays high, and no further reads or writes are issued, even if more requests arrive, until `arm` is lowered.
- R10: Lowering `arm` returns the channel to idle and clears `err`. After re-arming, streaming restarts at `src_base` with fresh loop counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Channel enable. Low means idle, and reloads the descriptor |
| src_base | input | ADDR_W | Ring buffer start address, sampled while idle |
| dst_addr | input | ADDR_W | Peripheral data register address, sampled while idle |
| req | input | 1 | Peripheral request for one minor loop |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_ack | input | 1 | Memory read accepted, data valid |
| mem_rd_data | input | DATA_W | Memory read data |
| mem_rd_err | input | 1 | Memory read error, valid with ack |
| per_wr_req | output | 1 | Peripheral write request |
| per_wr_addr | output | ADDR_W | Peripheral write address |
| per_wr_data | output | DATA_W | Peripheral write data |
| per_wr_ack | input | 1 | Peripheral write accepted |
| per_wr_err | input | 1 | Peripheral write error, valid with ack |
| irq | output | 1 | Major loop complete pulse |
| err | output | 1 | Sticky bus error flag |
| buf_pos | output | MOD_BITS | Ring buffer offset of the next read |

## Verification
The assertions assume that the slaves give an ack only while the matching request is high, and hold it for a single cycle. They also assume that the error bit matters only together with an ack, and that `src_base` and `dst_addr` change only while `arm` is low. The bench's responders check the request level at the falling edge and answer with a one-cycle ack, raising the error bit only on a chosen beat. The bench changes the descriptor only while the channel is disarmed. The base address sits near the top of a small window, so wrap is hit early in the run. Extra requests are pulsed in the middle of a loop to check that they are ignored.

// File: rtl/circ_dma_pkg.sv
package circ_dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_HALT  = 3'd4
    } dma_state_e;
endpackage

// File: rtl/circ_dma_modaddr.sv
module circ_dma_modaddr #(
    parameter int ADDR_W   = 32,
    parameter int MOD_BITS = 17,
    parameter int SRC_STEP = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    generate
        if (MOD_BITS >= ADDR_W) begin : g_full
            assign nxt_addr = cur_addr + ADDR_W'(SRC_STEP);
        end else begin : g_mod
            logic [MOD_BITS-1:0] low_sum;
            assign low_sum  = cur_addr[MOD_BITS-1:0] + MOD_BITS'(SRC_STEP);
            assign nxt_addr = {cur_addr[ADDR_W-1:MOD_BITS], low_sum};
        end
    endgenerate
endmodule

// File: rtl/circ_dma_loopctr.sv
module circ_dma_loopctr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (step)
            cnt_d = last ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/circ_dma_channel.sv
module circ_dma_channel
    import circ_dma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int MINOR_BEATS = 16,
    parameter int MAJOR_COUNT = 512,
    parameter int MOD_BITS    = 17,
    parameter int SRC_STEP    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [ADDR_W-1:0]   src_base,
    input  logic [ADDR_W-1:0]   dst_addr,
    input  logic                req,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_ack,
    input  logic [DATA_W-1:0]   mem_rd_data,
    input  logic                mem_rd_err,
    output logic                per_wr_req,
    output logic [ADDR_W-1:0]   per_wr_addr,
    output logic [DATA_W-1:0]   per_wr_data,
    input  logic                per_wr_ack,
    input  logic                per_wr_err,
    output logic                irq,
    output logic                err,
    output logic [MOD_BITS-1:0] buf_pos
);
    localparam int HI_W = (ADDR_W > MOD_BITS) ? ADDR_W - MOD_BITS : 1;

    typedef struct packed {
        dma_state_e        st;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [HI_W-1:0]   win;
        logic [DATA_W-1:0] data;
        logic              irq;
        logic              err;
    } chan_regs_t;

    chan_regs_t        r_d, r_q;
    logic [ADDR_W-1:0] src_next;
    logic              beat_done, beat_last, major_last, cnt_clear;

    circ_dma_modaddr #(
        .ADDR_W  (ADDR_W),
        .MOD_BITS(MOD_BITS),
        .SRC_STEP(SRC_STEP)
    ) i_modaddr (
        .cur_addr(r_q.src),
        .nxt_addr(src_next)
    );

    assign beat_done = (r_q.st == ST_WRITE) && per_wr_ack && !per_wr_err;
    assign cnt_clear = (r_q.st == ST_IDLE);

    circ_dma_loopctr #(.LIMIT(MINOR_BEATS)) i_beat_ctr (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
        .step(beat_done), .last(beat_last)
    );

    circ_dma_loopctr #(.LIMIT(MAJOR_COUNT)) i_major_ctr (
        .clk(clk), .rst_n(rst_n), .clear(cnt_clear),
        .step(beat_done && beat_last), .last(major_last)
    );

    function automatic logic [HI_W-1:0] upper_bits(input logic [ADDR_W-1:0] a);
        logic [ADDR_W+HI_W-1:0] ext;
        ext = {{HI_W{1'b0}}, a};
        return (MOD_BITS >= ADDR_W) ? '0 : ext[MOD_BITS +: HI_W];
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.src = src_base;
                r_d.dst = dst_addr;
                r_d.win = upper_bits(src_base);
                r_d.err = 1'b0;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (req) r_d.st = ST_READ;
            end
            ST_READ: begin
                if (mem_rd_ack) begin
                    if (mem_rd_err) begin
                        r_d.st  = ST_HALT;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.data = mem_rd_data;
                        r_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (per_wr_ack) begin
                    if (per_wr_err) begin
                        r_d.st  = ST_HALT;
                        r_d.err = 1'b1;
                    end else begin
                        r_d.src = src_next;
                        if (beat_last) begin
                            r_d.st  = ST_WAIT;
                            r_d.irq = major_last;
                        end else begin
                            r_d.st = ST_READ;
                        end
                    end
                end
            end
            default: r_d.st = ST_HALT;
        endcase
        if (!arm) begin
            r_d.st  = ST_IDLE;
            r_d.irq = 1'b0;
            if (r_q.st == ST_IDLE) r_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_req  = (r_q.st == ST_READ);
    assign mem_rd_addr = r_q.src;
    assign per_wr_req  = (r_q.st == ST_WRITE);
    assign per_wr_addr = r_q.dst;
    assign per_wr_data = r_q.data;
    assign irq         = r_q.irq;
    assign err         = r_q.err;
    assign buf_pos     = r_q.src[MOD_BITS-1:0];

    assert_one_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && per_wr_req));

    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack && arm) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_rd_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (upper_bits(mem_rd_addr) == r_q.win));

    assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(per_wr_req && per_wr_ack));

    assert_err_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_rd_req && !per_wr_req));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && arm) |=> err);
endmodule

// File: tb/test_circ_dma_channel.sv
module test_circ_dma_channel;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int MINOR = 4;
    localparam int MAJOR = 3;
    localparam int MODB  = 6;
    localparam int STEP  = 4;
    localparam logic [AW-1:0] BASE = 32'h1000_0030;
    localparam logic [AW-1:0] DST  = 32'h4002_0020;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic req = 1'b0;
    logic [AW-1:0] src_base = BASE;
    logic [AW-1:0] dst_addr = DST;
    logic mem_rd_req, per_wr_req, irq, err;
    logic [AW-1:0] mem_rd_addr, per_wr_addr;
    logic [DW-1:0] per_wr_data;
    logic mem_rd_ack = 1'b0, mem_rd_err = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic per_wr_ack = 1'b0, per_wr_err = 1'b0;
    logic [MODB-1:0] buf_pos;

    int n_total = 0, n_fail = 0;
    int irq_cnt = 0, rd_seen = 0, wr_seen = 0, minors_done = 0;
    bit chk_en = 1'b1, inj_rd = 1'b0, inj_wr = 1'b0;
    logic [AW-1:0] model_src = BASE;
    logic [AW-1:0] exp_rd_q[$];
    logic [DW-1:0] exp_wr_q[$];

    always #4 clk = ~clk;

    circ_dma_channel #(
        .ADDR_W(AW), .DATA_W(DW), .MINOR_BEATS(MINOR),
        .MAJOR_COUNT(MAJOR), .MOD_BITS(MODB), .SRC_STEP(STEP)
    ) i_circ_dma_channel (
        .clk(clk), .rst_n(rst_n), .arm(arm), .src_base(src_base),
        .dst_addr(dst_addr), .req(req),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
        .per_wr_req(per_wr_req), .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
        .per_wr_ack(per_wr_ack), .per_wr_err(per_wr_err),
        .irq(irq), .err(err), .buf_pos(buf_pos)
    );

    function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
        return (a * 32'd2654435761) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // read responder + monitor
    always @(negedge clk) begin
        if (mem_rd_req && !mem_rd_ack) begin
            rd_seen++;
            mem_rd_ack  = 1'b1;
            mem_rd_data = pattern(mem_rd_addr);
            mem_rd_err  = inj_rd;
            inj_rd      = 1'b0;
            if (chk_en) begin
                if (exp_rd_q.size() == 0)
                    check(1'b0, "R6 unexpected read", 64'(mem_rd_addr), 64'd0);
                else
                    check(mem_rd_addr == exp_rd_q.pop_front(), "R3/R4 read address",
                          64'(mem_rd_addr), 64'(model_src));
            end
        end else begin
            mem_rd_ack = 1'b0;
            mem_rd_err = 1'b0;
        end
    end

    // write responder + monitor
    always @(negedge clk) begin
        if (per_wr_req && !per_wr_ack) begin
            wr_seen++;
            per_wr_ack = 1'b1;
            per_wr_err = inj_wr;
            inj_wr     = 1'b0;
            if (chk_en) begin
                check(per_wr_addr == DST, "R5 write address", 64'(per_wr_addr), 64'(DST));
                if (exp_wr_q.size() == 0) begin
                    check(1'b0, "R6 unexpected write", 64'(per_wr_data), 64'd0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_wr_q.pop_front();
                    check(per_wr_data == e, "R2 write data", 64'(per_wr_data), 64'(e));
                end
            end
        end else begin
            per_wr_ack = 1'b0;
            per_wr_err = 1'b0;
        end
    end

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic run_minor(input bit extra_req);
        for (int b = 0; b < MINOR; b++) begin
            exp_rd_q.push_back(model_src);
            exp_wr_q.push_back(pattern(model_src));
            model_src = {model_src[AW-1:MODB], MODB'(model_src[MODB-1:0] + MODB'(STEP))};
        end
        pulse_req();
        if (extra_req) begin
            repeat (2) @(negedge clk);
            pulse_req();   // R6: must be ignored mid-loop
        end
        for (int w = 0; w < 200 && exp_wr_q.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, "R2 beats per request",
              64'(exp_wr_q.size()), 64'd0);
        minors_done++;
        check(irq_cnt == minors_done / MAJOR, "R7 interrupt count",
              64'(irq_cnt), 64'(minors_done / MAJOR));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_rd_req && !per_wr_req && !irq && !err, "R1 reset outputs",
              64'({mem_rd_req, per_wr_req, irq, err}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_rd_req && !per_wr_req && !irq && !err, "R1 idle outputs",
              64'({mem_rd_req, per_wr_req, irq, err}), 64'd0);
        arm = 1'b1;
        repeat (2) @(negedge clk);
        check(buf_pos == BASE[MODB-1:0], "R3 start position", 64'(buf_pos), 64'(BASE[MODB-1:0]));

        for (int m = 0; m < 2 * MAJOR; m++) begin
            run_minor(m == 1 || m == 4);
            if ((m + 1) % MAJOR == 0) begin
                logic [MODB-1:0] ep;
                ep = MODB'(BASE[MODB-1:0] + MODB'((m + 1) * MINOR * STEP));
                check(buf_pos == ep, "R8 position after major", 64'(buf_pos), 64'(ep));
            end
        end

        // read error
        chk_en = 1'b0;
        inj_rd = 1'b1;
        pulse_req();
        repeat (6) @(negedge clk);
        check(err == 1'b1, "R9 read error flag", 64'(err), 64'd1);
        begin
            int r0, w0, i0;
            r0 = rd_seen; w0 = wr_seen; i0 = irq_cnt;
            pulse_req();
            repeat (10) @(negedge clk);
            check(rd_seen == r0 && wr_seen == w0, "R9 halted no access",
                  64'(rd_seen), 64'(r0));
            check(err == 1'b1 && irq_cnt == i0, "R9 error sticky", 64'(err), 64'd1);
        end

        // disarm / rearm
        arm = 1'b0;
        repeat (3) @(negedge clk);
        check(err == 1'b0, "R10 disarm clears error", 64'(err), 64'd0);
        check(buf_pos == BASE[MODB-1:0], "R10 position reloaded", 64'(buf_pos),
              64'(BASE[MODB-1:0]));
        pulse_req();
        repeat (4) @(negedge clk);
        check(!mem_rd_req && !per_wr_req, "R10 idle ignores request", 64'(mem_rd_req), 64'd0);
        arm = 1'b1;
        chk_en = 1'b1;
        model_src = BASE;
        minors_done = 0;
        irq_cnt = 0;
        repeat (2) @(negedge clk);
        run_minor(1'b0);

        // write error on first write of a loop
        chk_en = 1'b0;
        inj_wr = 1'b1;
        pulse_req();
        repeat (6) @(negedge clk);
        check(err == 1'b1, "R9 write error flag", 64'(err), 64'd1);
        begin
            int w1;
            w1 = wr_seen;
            pulse_req();
            repeat (8) @(negedge clk);
            check(wr_seen == w1 && !mem_rd_req, "R9 write error halts", 64'(wr_seen), 64'(w1));
        end
        arm = 1'b0;
        repeat (3) @(negedge clk);
        arm = 1'b1;
        chk_en = 1'b1;
        model_src = BASE;
        minors_done = 0;
        irq_cnt = 0;
        repeat (2) @(negedge clk);
        for (int m = 0; m < MAJOR; m++) run_minor(1'b0);
        begin
            logic [MODB-1:0] ep2;
            ep2 = MODB'(BASE[MODB-1:0] + MODB'(MAJOR * MINOR * STEP));
            check(buf_pos == ep2, "R8 position after rearm major", 64'(buf_pos), 64'(ep2));
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule